// File: doc/BRIEF.md
# Video Vertical Capture Start Gate

This block decides, line by line, whether an incoming video scanline goes on to capture. A frame-sync strobe begins each field. Every line-start strobe after it advances a line counter. Once the counter reaches the programmed first valid line, that line and every later line of the field are flagged valid. The flag drops again at the next frame sync.

A 32-bit control word holds two 10-bit first-line values, one for each field of interlaced video. In progressive mode only the second-field value is used. The field identifier and the scan mode are sampled at frame sync, and the chosen start value is captured then. As a result, a write made during a field only takes effect from the next field. Downstream logic uses `line_valid` as a per-line enable for its pixel path.

Top module: `vgate_top`

## Requirements
- R1: After reset, `line_valid` is 0 and a read of the control word at offset 0x0C returns 0x00000000.
- R2: A write with `bus_sel`=1, `bus_wr`=1 and `bus_addr`=0x0C stores bits 9:0 as the first-field start and bits 25:16 as the second-field start. A read at 0x0C returns the two fields in those same positions.
- R3: Bits 31:26 and 15:10 of the control word are read-only. Writing them has no effect and they read as 0. A write to any offset other than 0x0C leaves the control word unchanged.
- R4: The line counter is cleared at each frame sync. The first line strobe after a frame sync is line index 0, and each further line strobe adds one.
- R5: A line is flagged valid if its index equals the active start or if an earlier line of the same field matched. `line_valid` takes the line's value at the clock edge that samples the line strobe and holds it until the next strobe.
- R6: In interlaced mode (`interlaced`=1), `field_id`=0 at frame sync selects the first-field start and `field_id`=1 selects the second-field start.
- R7: In progressive mode (`interlaced`=0), the second-field start applies to every field regardless of `field_id`. The first-field start has no effect.
- R8: With an active start of 0, the first line after frame sync is already valid.
- R9: A control-word write made during a field leaves that field's gating unchanged and applies from the next frame sync.
- R10: The line counter saturates at 1023 and never wraps. With start 1023, line 1022 is invalid, line 1023 is valid, and later lines stay valid.
- R11: When frame sync and a line strobe occur in the same cycle, the frame sync wins and that line is not counted.
- R12: A frame sync drives `line_valid` to 0 at the same clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | One-cycle strobe starting a field |
| line_strobe | input | 1 | One-cycle strobe at each line start |
| field_id | input | 1 | Field identifier, 0 = first, 1 = second |
| interlaced | input | 1 | 1 = interlaced, 0 = progressive |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading the control word |
| line_valid | output | 1 | Current line passes on for capture |

## Verification
Interlaced fields use different first-field and second-field starts, so a swapped field selection shows up as a wrong first valid line. Progressive fields run with both `field_id` values and with a first-field value that differs from the second. Any use of the ignored field is therefore visible. A mid-field write to a smaller start value separates the latched start from the live register value. A frame sync that coincides with a line strobe, and a 1030-line field with start 1023, exercise the counter-clear priority and the saturation edge.

// File: rtl/vgate_pkg.sv
package vgate_pkg;
  localparam int unsigned DEF_LINE_W  = 10;
  localparam int unsigned DEF_ADDR_W  = 8;
  localparam int unsigned DEF_HI_LSB  = 16;
  localparam int unsigned WORD_W      = 32;

  function automatic logic [WORD_W-1:0] field_mask(input int unsigned lsb,
                                                   input int unsigned width);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++)
      if (i >= lsb && i < lsb + width) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/vgate_regfile.sv
module vgate_regfile
  import vgate_pkg::*;
#(
  parameter int unsigned LINE_W  = DEF_LINE_W,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned HI_LSB  = DEF_HI_LSB,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [LINE_W-1:0] start_first,
  output logic [LINE_W-1:0] start_second,
  output logic              wr_hit
);
  localparam int unsigned HI_MSB = HI_LSB + LINE_W - 1;

  function automatic logic [WORD_W-1:0] pack_word(input logic [LINE_W-1:0] a,
                                                  input logic [LINE_W-1:0] b);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LINE_W-1:0]      = a;
    w[HI_MSB:HI_LSB]   = b;
    return w;
  endfunction

  logic addr_hit;
  logic rd_hit;

  assign addr_hit = bus_sel && (bus_addr == REG_OFS);
  assign wr_hit   = addr_hit && bus_wr;
  assign rd_hit   = addr_hit && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_first  <= '0;
      start_second <= '0;
    end else if (wr_hit) begin
      start_first  <= bus_wdata[LINE_W-1:0];
      start_second <= bus_wdata[HI_MSB:HI_LSB];
    end
  end

  assign bus_rdata = rd_hit ? pack_word(start_first, start_second) : '0;
endmodule

// File: rtl/vgate_start_latch.sv
module vgate_start_latch #(
  parameter int unsigned LINE_W = vgate_pkg::DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              interlaced,
  input  logic              field_id,
  input  logic [LINE_W-1:0] start_first,
  input  logic [LINE_W-1:0] start_second,
  output logic [LINE_W-1:0] active_start
);
  function automatic logic [LINE_W-1:0] pick_start(input logic ilace,
                                                   input logic fld,
                                                   input logic [LINE_W-1:0] a,
                                                   input logic [LINE_W-1:0] b);
    if (ilace && !fld) return a;
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_start <= '0;
    else if (frame_sync)
      active_start <= pick_start(interlaced, field_id, start_first, start_second);
  end
endmodule

// File: rtl/vgate_line_counter.sv
module vgate_line_counter #(
  parameter int unsigned LINE_W = vgate_pkg::DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_strobe,
  output logic [LINE_W-1:0] line_index,
  output logic              line_take
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  function automatic logic [LINE_W-1:0] sat_inc(input logic [LINE_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign line_take = line_strobe && !frame_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_index <= '0;
    else if (frame_sync)
      line_index <= '0;
    else if (line_take)
      line_index <= sat_inc(line_index);
  end
endmodule

// File: rtl/vgate_window.sv
module vgate_window #(
  parameter int unsigned LINE_W = vgate_pkg::DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_take,
  input  logic [LINE_W-1:0] line_index,
  input  logic [LINE_W-1:0] active_start,
  output logic              window_open,
  output logic              line_valid
);
  logic start_hit;
  logic open_now;

  assign start_hit = (line_index == active_start);
  assign open_now  = window_open || start_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_open <= 1'b0;
      line_valid  <= 1'b0;
    end else if (frame_sync) begin
      window_open <= 1'b0;
      line_valid  <= 1'b0;
    end else if (line_take) begin
      window_open <= open_now;
      line_valid  <= open_now;
    end
  end
endmodule

// File: rtl/vgate_top.sv
module vgate_top
  import vgate_pkg::*;
#(
  parameter int unsigned LINE_W  = DEF_LINE_W,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned HI_LSB  = DEF_HI_LSB,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_strobe,
  input  logic              field_id,
  input  logic              interlaced,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              line_valid
);
  logic [LINE_W-1:0] start_first;
  logic [LINE_W-1:0] start_second;
  logic [LINE_W-1:0] active_start;
  logic [LINE_W-1:0] line_index;
  logic              line_take;
  logic              wr_hit;
  logic              window_open;

  vgate_regfile #(
    .LINE_W (LINE_W),
    .ADDR_W (ADDR_W),
    .HI_LSB (HI_LSB),
    .REG_OFS(REG_OFS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .start_first (start_first),
    .start_second(start_second),
    .wr_hit      (wr_hit)
  );

  vgate_start_latch #(.LINE_W(LINE_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sync  (frame_sync),
    .interlaced  (interlaced),
    .field_id    (field_id),
    .start_first (start_first),
    .start_second(start_second),
    .active_start(active_start)
  );

  vgate_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .line_strobe(line_strobe),
    .line_index (line_index),
    .line_take  (line_take)
  );

  vgate_window #(.LINE_W(LINE_W)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sync  (frame_sync),
    .line_take   (line_take),
    .line_index  (line_index),
    .active_start(active_start),
    .window_open (window_open),
    .line_valid  (line_valid)
  );
endmodule

// File: rtl/vgate_checker.sv
module vgate_checker
  import vgate_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned HI_LSB = DEF_HI_LSB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              line_strobe,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              line_valid,
  input logic              window_open,
  input logic [LINE_W-1:0] line_index,
  input logic [LINE_W-1:0] active_start
);
  localparam logic [WORD_W-1:0] LIVE_BITS =
    field_mask(0, LINE_W) | field_mask(HI_LSB, LINE_W);
  localparam logic [LINE_W-1:0] IDX_MAX = '1;

  p_sync_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> !line_valid);

  p_hold_between_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && !line_strobe) |=> $stable(line_valid));

  p_window_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && !frame_sync) |=> window_open);

  p_valid_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> window_open);

  p_count_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (line_index == '0));

  p_sync_beats_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && line_strobe) |=> (line_index == '0 && !line_valid));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_index == IDX_MAX && !frame_sync) |=> (line_index == IDX_MAX));

  p_start_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(active_start));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE_BITS) == '0);
endmodule

bind vgate_top vgate_checker #(.LINE_W(LINE_W), .HI_LSB(HI_LSB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_sync  (frame_sync),
  .line_strobe (line_strobe),
  .bus_rdata   (bus_rdata),
  .line_valid  (line_valid),
  .window_open (window_open),
  .line_index  (line_index),
  .active_start(active_start)
);

// File: tb/sim_vgate_top.sv
module sim_vgate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        line_strobe = 1'b0;
  logic        field_id = 1'b0;
  logic        interlaced = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        line_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vgate_top u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .line_strobe(line_strobe),
    .field_id(field_id), .interlaced(interlaced), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_valid(line_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic reg_read_check(input string req, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h0C;
    #1 check(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  // Starts a field; line_valid must read 0 one edge later (R12).
  task automatic field_start(input logic ilace, input logic fld);
    @(negedge clk);
    interlaced = ilace; field_id = fld; frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    check("R12 sync clears valid", {31'd0, line_valid}, 32'd0);
  endtask

  task automatic one_line(input string req, input logic exp);
    @(negedge clk);
    line_strobe = 1'b1;
    @(negedge clk);
    line_strobe = 1'b0;
    check(req, {31'd0, line_valid}, {31'd0, exp});
  endtask

  task automatic run_lines(input string req, input int first, input int n, input int start);
    for (int i = first; i < first + n; i++) begin
      int idx;
      idx = (i > 1023) ? 1023 : i;
      one_line(req, idx >= start);
    end
  endtask

  task automatic t_reset;
    check("R1 valid after reset", {31'd0, line_valid}, 32'd0);
    reg_read_check("R1 word after reset", 32'h0000_0000);
  endtask

  task automatic t_register;
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_read_check("R3 reserved bits read 0", 32'h03FF_03FF);
    reg_write(8'h0C, 32'h0005_0003);
    reg_read_check("R2 field positions", 32'h0005_0003);
    reg_write(8'h10, 32'h0011_0022);
    reg_read_check("R3 other offset ignored", 32'h0005_0003);
  endtask

  task automatic t_interlaced;
    reg_write(8'h0C, 32'h0005_0003);
    field_start(1'b1, 1'b0);
    run_lines("R6 first field start 3", 0, 8, 3);
    field_start(1'b1, 1'b1);
    run_lines("R6 second field start 5", 0, 8, 5);
  endtask

  task automatic t_progressive;
    reg_write(8'h0C, 32'h0006_0002);
    field_start(1'b0, 1'b0);
    run_lines("R7 progressive field 0", 0, 9, 6);
    field_start(1'b0, 1'b1);
    run_lines("R7 progressive field 1", 0, 9, 6);
  endtask

  task automatic t_zero_start;
    reg_write(8'h0C, 32'h0000_0009);
    field_start(1'b0, 1'b0);
    run_lines("R8 start 0 first line valid", 0, 3, 0);
  endtask

  task automatic t_mid_write;
    reg_write(8'h0C, 32'h0007_0003);
    field_start(1'b1, 1'b0);
    run_lines("R9 before write", 0, 2, 3);
    reg_write(8'h0C, 32'h0007_0000);
    run_lines("R9 write held off", 2, 3, 3);
    field_start(1'b1, 1'b0);
    run_lines("R9 new value after sync", 0, 2, 0);
  endtask

  task automatic t_collision;
    reg_write(8'h0C, 32'h0002_0002);
    field_start(1'b0, 1'b0);
    run_lines("R4 count from 0", 0, 4, 2);
    @(negedge clk);
    frame_sync = 1'b1; line_strobe = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0; line_strobe = 1'b0;
    check("R11 sync wins valid", {31'd0, line_valid}, 32'd0);
    run_lines("R11 line not counted", 0, 4, 2);
  endtask

  task automatic t_saturate;
    reg_write(8'h0C, 32'h03FF_0000);
    field_start(1'b0, 1'b1);
    run_lines("R10 saturation at 1023", 0, 1030, 1023);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_register();
    t_interlaced();
    t_progressive();
    t_zero_start();
    t_mid_write();
    t_collision();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule